// File: doc/BRIEF.md
# Main-Clock Failure Detector with Ring-Oscillator Failover

This block watches a main oscillator input from the always-running ring-oscillator domain. A two-stage synchronizer feeds a rising-edge detector. A window counter clocked by the ring oscillator then decides, one window at a time, whether the main clock is alive. If a whole window passes with no main-clock edge, the clock is declared stopped. If a run of windows that each hold at least one edge follows a stop, the clock is declared restarted.

Each stop or restart event sets a sticky detection flag, provided detection is enabled. What happens next depends on an action-select bit:
- With the action select at 1, the 0-to-1 transition of the flag raises a one-cycle interrupt pulse. If the CPU runs from the main clock (not from the PLL), the clock-select bit also switches to the ring oscillator on a stop.
- With the action select at 0, a stop produces a one-cycle reset-request pulse.

Software uses a byte-wide control/status register:
- Writes to it are accepted only while a protect-enable input is 1.
- The enable bit is also frozen while a clock-modification lock input is 1.
- The flag clears only when software writes 0 to it.
- A reset caused by the detector clears the flag and keeps the configuration bits.

Top module: `cfd_top`

Register layout (read and write share one byte; other bits read 0 and ignore writes):

| Bit | Meaning |
|-----|---------|
| 0 | Detection enable |
| 1 | Clock select (1 = ring oscillator) |
| 2 | Sticky detection flag |
| 3 | Main clock not oscillating (read-only) |
| 7 | Action select (1 = interrupt, 0 = reset request) |

## Requirements
- R1: After `rst_n` is released, `reg_rdata` reads 0x00, and bits 6:4 always read 0, whatever value was written to them.
- R2: A write with `prot_en` at 0 changes no register bit. With `prot_en` at 1, the write updates bit 0, bit 1 and bit 7 from `reg_wdata`, and clears bit 2 when the written bit 2 is 0.
- R3: While `mod_lock` is 1, a write leaves the enable bit (bit 0) unchanged, and the other bits of the same write still take effect.
- R4: The clock is declared stopped when a full window of WIN (default 16) ring-oscillator cycles contains no synchronized main-clock rising edge. It is declared restarted after RESTART_WINS (default 4) consecutive windows that each contain an edge. Bit 3 and `main_dead` read 1 while the clock is declared stopped. When enabled, each event sets the flag (bit 2).
- R5: `irq_pulse` is high for one cycle only when the flag goes from 0 to 1 while bit 7 is 1. An event that occurs while the flag is already 1 raises no interrupt.
- R6: Writing 1 to bit 2 has no effect, and only a protected write of 0 to bit 2 clears the flag.
- R7: On a detected stop with bit 0 = 1, bit 7 = 1 and `cpu_on_pll` = 0, bit 1 (and `ref_sel`) becomes 1 automatically. With `cpu_on_pll` = 1, bit 1 keeps its value and only the interrupt is raised.
- R8: On a detected stop with bit 0 = 1 and bit 7 = 0, `rst_req` is high for exactly one cycle, and no interrupt is raised.
- R9: A pulse on `osc_rst` clears the flag and leaves bits 0, 1 and 7 unchanged.
- R10: With bit 0 = 0, stop and restart events never set the flag, raise `irq_pulse` or raise `rst_req`. `main_dead` and bit 3 still track the clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Ring-oscillator reference clock; the whole block runs on it |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| main_clk | input | 1 | Main oscillator being monitored, asynchronous to clk_ref |
| cpu_on_pll | input | 1 | 1 when the CPU clock source is the PLL, 0 when it is the main clock |
| mod_lock | input | 1 | Clock-modification lock; freezes the enable bit |
| prot_en | input | 1 | Write protect enable; writes are accepted only when 1 |
| osc_rst | input | 1 | Synchronous reset that results from oscillation-stop detection |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| ref_sel | output | 1 | Clock select: 1 selects the ring oscillator |
| main_dead | output | 1 | Live main-clock-not-oscillating status |
| irq_pulse | output | 1 | One-cycle interrupt request |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The bench runs random protected and locked writes against a reference model. It then targets several corner cases, each described with the fault it exposes:
- A second detection while the flag is already set must raise no interrupt. A design that fires on every event instead of on the flag's rising edge would count an extra interrupt.
- A write of 1 to the flag must not clear it. A design that decodes the flag bit loosely would drop the flag.
- A stop while the CPU runs from the PLL must not switch the clock select. A design that fails over unconditionally would set bit 1.
- A detector reset must keep the configuration bits. A design that reset the whole register would lose them.
- With detection disabled, the live monitor must still toggle while the flag, interrupt and reset request stay quiet. A design that gates the detector rather than its consequences would freeze the monitor.

// File: rtl/cfd_pkg.sv
package cfd_pkg;
   localparam int REG_W   = 8;
   localparam int B_EN    = 0;
   localparam int B_SEL   = 1;
   localparam int B_FLAG  = 2;
   localparam int B_DEAD  = 3;
   localparam int B_ACT   = 7;

   typedef struct packed {
      logic en;
      logic sel;
      logic flag;
      logic act;
   } cfd_cfg_t;

   function automatic logic [REG_W-1:0] cfd_pack(input cfd_cfg_t c, input logic dead);
      logic [REG_W-1:0] r;
      r         = '0;
      r[B_EN]   = c.en;
      r[B_SEL]  = c.sel;
      r[B_FLAG] = c.flag;
      r[B_DEAD] = dead;
      r[B_ACT]  = c.act;
      return r;
   endfunction
endpackage

// File: rtl/cfd_edge_sync.sv
module cfd_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("cfd_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-1:0], async_in};
   end

   assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/cfd_window_mon.sv
module cfd_window_mon #(
   parameter int WIN          = 16,
   parameter int RESTART_WINS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic edge_i,
   output logic dead,
   output logic stop_evt,
   output logic restart_evt
);
   localparam int CW = (WIN > 1) ? $clog2(WIN) : 1;
   localparam int GW = $clog2(RESTART_WINS + 1);
   localparam logic [CW-1:0] LAST = CW'(WIN - 1);

   generate
      if (WIN < 4) begin : g_bad_win
         $error("cfd_window_mon: WIN must be at least 4");
      end
      if (RESTART_WINS < 1) begin : g_bad_rs
         $error("cfd_window_mon: RESTART_WINS must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic          seen;
   logic          last;
   logic          seen_any;
   logic          good_done;
   logic          good_win;

   assign last     = (cnt == LAST);
   assign seen_any = seen | edge_i;
   assign good_win = last & seen_any & dead;

   generate
      if (RESTART_WINS == 1) begin : g_single
         assign good_done = 1'b1;
      end else begin : g_count
         logic [GW-1:0] good;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  good <= '0;
            else if (last && !seen_any)  good <= '0;
            else if (good_win) begin
               if (good_done) good <= '0;
               else           good <= good + 1'b1;
            end
         end
         assign good_done = (good == GW'(RESTART_WINS - 1));
      end
   endgenerate

   assign stop_evt    = last & ~seen_any & ~dead;
   assign restart_evt = good_win & good_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         seen <= 1'b0;
         dead <= 1'b0;
      end else begin
         if (last) begin
            cnt  <= '0;
            seen <= 1'b0;
         end else begin
            cnt  <= cnt + 1'b1;
            if (edge_i) seen <= 1'b1;
         end
         if (stop_evt)         dead <= 1'b1;
         else if (restart_evt) dead <= 1'b0;
      end
   end
endmodule

// File: rtl/cfd_ctrl_reg.sv
module cfd_ctrl_reg
   import cfd_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             osc_rst,
   input  logic             we,
   input  logic             prot,
   input  logic             lock,
   input  logic [REG_W-1:0] wdata,
   input  logic             cpu_on_pll,
   input  logic             stop_evt,
   input  logic             restart_evt,
   output cfd_cfg_t         cfg,
   output logic             irq_o,
   output logic             rstreq_o
);
   logic wr;
   logic set_now;
   logic fail_now;

   assign wr       = we & prot;
   assign set_now  = cfg.en & (stop_evt | restart_evt);
   assign fail_now = cfg.en & cfg.act & stop_evt & ~cpu_on_pll;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg      <= '0;
         irq_o    <= 1'b0;
         rstreq_o <= 1'b0;
      end else begin
         if (wr && !lock) cfg.en <= wdata[B_EN];
         if (fail_now)    cfg.sel <= 1'b1;
         else if (wr)     cfg.sel <= wdata[B_SEL];
         if (wr)          cfg.act <= wdata[B_ACT];
         if (set_now)                      cfg.flag <= 1'b1;
         else if (osc_rst)                 cfg.flag <= 1'b0;
         else if (wr && !wdata[B_FLAG])    cfg.flag <= 1'b0;
         irq_o    <= set_now & ~cfg.flag & cfg.act;
         rstreq_o <= stop_evt & cfg.en & ~cfg.act;
      end
   end
endmodule

// File: rtl/cfd_top.sv
module cfd_top
   import cfd_pkg::*;
#(
   parameter int WIN          = 16,
   parameter int RESTART_WINS = 4,
   parameter int SYNC_STAGES  = 2
) (
   input  logic             clk_ref,
   input  logic             rst_n,
   input  logic             main_clk,
   input  logic             cpu_on_pll,
   input  logic             mod_lock,
   input  logic             prot_en,
   input  logic             osc_rst,
   input  logic             reg_we,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   output logic             ref_sel,
   output logic             main_dead,
   output logic             irq_pulse,
   output logic             rst_req
);
   logic     main_rise;
   logic     stop_evt;
   logic     restart_evt;
   cfd_cfg_t cfg;

   cfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk_ref),
      .rst_n    (rst_n),
      .async_in (main_clk),
      .rise     (main_rise)
   );

   cfd_window_mon #(.WIN(WIN), .RESTART_WINS(RESTART_WINS)) u_mon (
      .clk         (clk_ref),
      .rst_n       (rst_n),
      .edge_i      (main_rise),
      .dead        (main_dead),
      .stop_evt    (stop_evt),
      .restart_evt (restart_evt)
   );

   cfd_ctrl_reg u_reg (
      .clk         (clk_ref),
      .rst_n       (rst_n),
      .osc_rst     (osc_rst),
      .we          (reg_we),
      .prot        (prot_en),
      .lock        (mod_lock),
      .wdata       (reg_wdata),
      .cpu_on_pll  (cpu_on_pll),
      .stop_evt    (stop_evt),
      .restart_evt (restart_evt),
      .cfg         (cfg),
      .irq_o       (irq_pulse),
      .rstreq_o    (rst_req)
   );

   assign reg_rdata = cfd_pack(cfg, main_dead);
   assign ref_sel   = cfg.sel;
endmodule

// File: rtl/cfd_checker.sv
module cfd_checker (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic act,
   input logic flag,
   input logic sel,
   input logic evt,
   input logic dead,
   input logic lock,
   input logic prot,
   input logic pll,
   input logic irq,
   input logic rreq
);
   AST_IRQ_ON_FLAG_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (flag && !$past(flag))); // R5
   AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq); // R5
   AST_FLAG_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(evt && en)); // R6
   AST_LOCK_HOLDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> $stable(en)); // R3
   AST_PROT_HOLDS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
      !prot |=> $stable(act)); // R2
   AST_RSTREQ_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      rreq |-> ($rose(dead) && !irq)); // R8
   AST_FAILOVER: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(dead) && $past(en && act && !pll)) |-> sel); // R7
   AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !$rose(flag)); // R10
endmodule

bind cfd_top cfd_checker u_chk (
   .clk  (clk_ref),
   .rst_n(rst_n),
   .en   (cfg.en),
   .act  (cfg.act),
   .flag (cfg.flag),
   .sel  (cfg.sel),
   .evt  (stop_evt | restart_evt),
   .dead (main_dead),
   .lock (mod_lock),
   .prot (prot_en),
   .pll  (cpu_on_pll),
   .irq  (irq_pulse),
   .rreq (rst_req)
);

// File: tb/sim_cfd_top.sv
module sim_cfd_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       main_clk = 1'b0;
   logic       cpu_on_pll = 1'b0;
   logic       mod_lock = 1'b0;
   logic       prot_en = 1'b0;
   logic       osc_rst = 1'b0;
   logic       reg_we = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       ref_sel, main_dead, irq_pulse, rst_req;

   logic mclk_run = 1'b1;
   int   n_chk = 0, n_fail = 0, irq_cnt = 0, rst_cnt = 0;
   logic e_en = 0, e_sel = 0, e_flag = 0, e_act = 0;

   cfd_top u0 (
      .clk_ref(clk), .rst_n(rst_n), .main_clk(main_clk), .cpu_on_pll(cpu_on_pll),
      .mod_lock(mod_lock), .prot_en(prot_en), .osc_rst(osc_rst), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ref_sel(ref_sel),
      .main_dead(main_dead), .irq_pulse(irq_pulse), .rst_req(rst_req)
   );

   always #4 clk = ~clk;

   initial begin
      #1;
      forever begin
         #20;
         if (mclk_run) main_clk = ~main_clk;
      end
   end

   always @(negedge clk) begin
      if (irq_pulse) irq_cnt++;
      if (rst_req)   rst_cnt++;
   end

   function automatic logic [7:0] exp_rd(input logic dead);
      return {e_act, 3'b000, dead, e_flag, e_sel, e_en};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] d, input logic p, input logic l);
      @(negedge clk);
      reg_wdata = d; prot_en = p; mod_lock = l; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0; prot_en = 1'b0; mod_lock = 1'b0;
      if (p) begin
         if (!l) e_en = d[0];
         e_sel = d[1];
         if (!d[2]) e_flag = 1'b0;
         e_act = d[7];
      end
   endtask

   initial begin
      #(200000 * 8);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [7:0] d;
      void'($urandom(32'h5eed1234));
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(2);
      chk("R1 reset value", reg_rdata, 8'h00);
      chk("R4 monitor after reset", main_dead, 1'b0);

      // random protected / locked writes, main clock running
      for (int k = 0; k < 40; k++) begin
         d = 8'($urandom);
         wr(d, 1'($urandom), 1'($urandom));
         chk("R2 R3 random write", reg_rdata, exp_rd(1'b0));
      end
      wr(8'h78, 1, 0);
      chk("R1 reserved bits read 0", reg_rdata, exp_rd(1'b0));

      // stop with interrupt mode, CPU on main clock
      wr(8'h81, 1, 0);
      cpu_on_pll = 1'b0;
      irq_cnt = 0; rst_cnt = 0;
      mclk_run = 1'b0;
      wait_cyc(50);
      e_flag = 1; e_sel = 1;
      chk("R4 stop monitor", main_dead, 1'b1);
      chk("R4 stop flag", reg_rdata, exp_rd(1'b1));
      chk("R7 failover sel", ref_sel, 1'b1);
      chk("R5 one irq", irq_cnt, 1);
      chk("R8 no reset req in irq mode", rst_cnt, 0);

      mclk_run = 1'b1;
      wait_cyc(110);
      chk("R4 restart monitor", main_dead, 1'b0);
      chk("R4 flag kept after restart", reg_rdata, exp_rd(1'b0));
      chk("R5 no irq while flag set", irq_cnt, 1);

      wr(8'h85, 1, 0);
      chk("R6 write 1 keeps flag", reg_rdata, exp_rd(1'b0));
      chk("R6 flag still 1", reg_rdata[2], 1'b1);
      wr(8'h81, 1, 0);
      chk("R6 write 0 clears flag", reg_rdata[2], 1'b0);

      // stop while CPU on PLL
      cpu_on_pll = 1'b1;
      mclk_run = 1'b0;
      wait_cyc(50);
      e_flag = 1;
      chk("R7 PLL keeps sel", ref_sel, 1'b0);
      chk("R5 irq on new flag rise", irq_cnt, 2);
      chk("R7 PLL register", reg_rdata, exp_rd(1'b1));
      mclk_run = 1'b1;
      wait_cyc(110);
      cpu_on_pll = 1'b0;
      chk("R5 restart with flag set no irq", irq_cnt, 2);

      // reset-request mode
      wr(8'h03, 1, 0);
      mclk_run = 1'b0;
      wait_cyc(50);
      e_flag = 1;
      chk("R8 reset request pulse", rst_cnt, 1);
      chk("R8 no irq in reset mode", irq_cnt, 2);
      chk("R8 flag set", reg_rdata, exp_rd(1'b1));

      @(negedge clk); osc_rst = 1'b1;
      @(negedge clk); osc_rst = 1'b0;
      e_flag = 0;
      chk("R9 detector reset keeps config", reg_rdata, 8'h0B);

      wr(8'h02, 1, 1);
      chk("R3 lock keeps enable", reg_rdata[0], 1'b1);
      wr(8'h80, 0, 0);
      chk("R2 unprotected write ignored", reg_rdata, exp_rd(1'b1));

      // detection disabled
      wr(8'h80, 1, 0);
      irq_cnt = 0; rst_cnt = 0;
      mclk_run = 1'b1;
      wait_cyc(110);
      chk("R10 monitor live on restart", main_dead, 1'b0);
      chk("R10 no flag on restart", reg_rdata, exp_rd(1'b0));
      mclk_run = 1'b0;
      wait_cyc(50);
      chk("R10 monitor live on stop", main_dead, 1'b1);
      chk("R10 no flag on stop", reg_rdata[2], 1'b0);
      chk("R10 no irq", irq_cnt, 0);
      chk("R10 no reset req", rst_cnt, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule